// File: doc/BRIEF.md
# Step-Serial Accumulator Shifter

This unit shifts or rotates an 8-bit accumulator together with a one-bit carry flag, one bit position per clock. A caller presents the accumulator value, the carry, and a control byte, then pulses `start`. The upper nibble of the control byte picks one of nine operations. The step count is not a binary number. It is the number of set bits in the lower nibble, so it lies between 0 and 4.

When the last step has been applied, the unit raises `done` for one cycle, with the result on `acc_out` and `carry_out`. An upper nibble outside the nine legal codes is reported on `illegal`, which goes high together with `done`. In that case the operands pass through without change. The result outputs hold their value until the next accepted start.

Control runs through three states:
- `ST_IDLE` waits for work and accepts a start.
- `ST_STEP` applies one single-bit step per cycle.
- `ST_DONE` presents the result for one cycle.

The transitions are:
- IDLE→STEP on a legal start with a nonzero count.
- IDLE→DONE on an illegal start or a start with a zero count.
- STEP→STEP while more than one step remains.
- STEP→DONE on the last step.
- DONE→IDLE always.

Top module: `shrot_unit`

## Requirements
- R1: After reset, `acc_out`, `carry_out`, `done`, `busy` and `illegal` are all 0.
- R2: The step count is the number of 1 bits in `ctrl[3:0]`. For a legal mode with count N>0, `done` rises in the (N+1)th cycle after the start edge. `busy` is high from the cycle after an accepted start through the `done` cycle.
- R3: Mode code `ctrl[7:4]`=0x0 shifts right and fills bit 7 with 0. Mode 0x8 shifts right and keeps bit 7 unchanged, so the sign is duplicated.
- R4: Mode 0x2 rotates right. The old bit 0 re-enters at bit 7.
- R5: Modes 0x1 and 0x3 both shift right through the carry. The old carry enters bit 7.
- R6: Mode 0x4 shifts left and fills bit 0 with 0. Mode 0x6 rotates left, and the old bit 7 re-enters at bit 0.
- R7: Modes 0x5 and 0x7 both shift left through the carry. The old carry enters bit 0.
- R8: In every right step the outgoing bit 0 becomes the new carry. In every left step the outgoing bit 7 becomes the new carry.
- R9: With `ctrl[3:0]`=0 in a legal mode, `done` is high in the cycle after start. The outputs equal the inputs.
- R10: Mode codes 0x9 to 0xF raise `illegal` together with `done` in the cycle after start. `acc_out`/`carry_out` equal the input operands. `illegal` is never high without `done`.
- R11: A `start` while `busy` is high is ignored. It changes neither the result nor the number of `done` pulses.
- R12: `done` lasts exactly one cycle. While idle with no start, `acc_out` and `carry_out` hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| acc_in | input | DATA_W | Accumulator operand |
| carry_in | input | 1 | Carry flag operand |
| ctrl | input | MODE_W+SEL_W | Upper nibble = mode code, lower nibble = step-count bit mask |
| acc_out | output | DATA_W | Result accumulator |
| carry_out | output | 1 | Result carry flag |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Mode code was not legal (valid with `done`) |
| busy | output | 1 | Operation in progress |

## Verification
The hardest situation to reach from the ports is a start that arrives while a four-step operation is still running. The stray start carries an illegal mode code and a fresh operand, which would produce an early `done` with `illegal` set if it were taken. To provoke it, the stimulus holds `start` high for several cycles straight after launching a rotate with all four count bits set. The scoreboard then demands exactly one `done`, at the cycle the first operation predicts, with `illegal` low. It also watches for several idle cycles afterwards, so that any extra `done` is caught.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_DONE
    } state_e;

    // What enters the vacated bit position on each step
    typedef enum logic [1:0] {
        FILL_ZERO,
        FILL_CARRY,
        FILL_WRAP,
        FILL_SIGN
    } fill_e;

    typedef struct packed {
        logic  legal;
        logic  to_left;
        fill_e fill;
    } op_s;

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0] mode,
    output op_s               op
);
    always_comb begin
        op = '{legal: 1'b1, to_left: 1'b0, fill: FILL_ZERO};
        unique case (mode)
            MODE_W'(4'h0): op = '{legal: 1'b1, to_left: 1'b0, fill: FILL_ZERO};
            MODE_W'(4'h1),
            MODE_W'(4'h3): op = '{legal: 1'b1, to_left: 1'b0, fill: FILL_CARRY};
            MODE_W'(4'h2): op = '{legal: 1'b1, to_left: 1'b0, fill: FILL_WRAP};
            MODE_W'(4'h4): op = '{legal: 1'b1, to_left: 1'b1, fill: FILL_ZERO};
            MODE_W'(4'h5),
            MODE_W'(4'h7): op = '{legal: 1'b1, to_left: 1'b1, fill: FILL_CARRY};
            MODE_W'(4'h6): op = '{legal: 1'b1, to_left: 1'b1, fill: FILL_WRAP};
            MODE_W'(4'h8): op = '{legal: 1'b1, to_left: 1'b0, fill: FILL_SIGN};
            default:       op = '{legal: 1'b0, to_left: 1'b0, fill: FILL_ZERO};
        endcase
    end
endmodule

// File: rtl/shrot_popcnt.sv
module shrot_popcnt #(
    parameter int SEL_W = 4,
    localparam int CW   = $clog2(SEL_W + 1)
) (
    input  logic [SEL_W-1:0] mask,
    output logic [CW-1:0]    count
);
    logic [CW-1:0] partial [0:SEL_W];

    assign partial[0] = '0;
    for (genvar g = 0; g < SEL_W; g++) begin : g_sum
        assign partial[g+1] = partial[g] + CW'(mask[g]);
    end
    assign count = partial[SEL_W];
endmodule

// File: rtl/shrot_step.sv
module shrot_step
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_s               op,
    input  logic [DATA_W-1:0] a,
    input  logic              v,
    output logic [DATA_W-1:0] y,
    output logic              v_next
);
    logic in_bit;

    always_comb begin
        in_bit = 1'b0;
        if (op.to_left) begin
            v_next = a[DATA_W-1];
            unique case (op.fill)
                FILL_CARRY: in_bit = v;
                FILL_WRAP:  in_bit = a[DATA_W-1];
                default:    in_bit = 1'b0;
            endcase
            y = {a[DATA_W-2:0], in_bit};
        end else begin
            v_next = a[0];
            unique case (op.fill)
                FILL_CARRY: in_bit = v;
                FILL_WRAP:  in_bit = a[0];
                FILL_SIGN:  in_bit = a[DATA_W-1];
                default:    in_bit = 1'b0;
            endcase
            y = {in_bit, a[DATA_W-1:1]};
        end
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MODE_W = 4,
    parameter int SEL_W  = 4,
    localparam int CTRL_W = MODE_W + SEL_W,
    localparam int CW     = $clog2(SEL_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              carry_in,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [DATA_W-1:0] acc_out,
    output logic              carry_out,
    output logic              done,
    output logic              illegal,
    output logic              busy
);
    state_e            state_q, state_d;
    op_s               op_dec, op_q;
    logic [CW-1:0]     steps_dec, steps_q;
    logic [DATA_W-1:0] acc_q, acc_step;
    logic              v_q, v_step, err_q;
    logic              accept;

    shrot_decode #(.MODE_W(MODE_W)) u_dec (
        .mode (ctrl[CTRL_W-1:SEL_W]),
        .op   (op_dec)
    );

    shrot_popcnt #(.SEL_W(SEL_W)) u_pop (
        .mask  (ctrl[SEL_W-1:0]),
        .count (steps_dec)
    );

    shrot_step #(.DATA_W(DATA_W)) u_step (
        .op     (op_q),
        .a      (acc_q),
        .v      (v_q),
        .y      (acc_step),
        .v_next (v_step)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = (!op_dec.legal || steps_dec == '0) ? ST_DONE : ST_STEP;
            end
            ST_STEP: if (steps_q == CW'(1)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            v_q     <= 1'b0;
            op_q    <= '{legal: 1'b0, to_left: 1'b0, fill: FILL_ZERO};
            steps_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            acc_q   <= acc_in;
            v_q     <= carry_in;
            op_q    <= op_dec;
            steps_q <= steps_dec;
            err_q   <= !op_dec.legal;
        end else if (state_q == ST_STEP) begin
            acc_q   <= acc_step;
            v_q     <= v_step;
            steps_q <= steps_q - CW'(1);
        end
    end

    // Outputs
    always_comb begin
        acc_out   = acc_q;
        carry_out = v_q;
        done      = (state_q == ST_DONE);
        busy      = (state_q != ST_IDLE);
        illegal   = (state_q == ST_DONE) && err_q;
    end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int DATA_W = 8,
    parameter int MODE_W = 4,
    parameter int SEL_W  = 4,
    localparam int CTRL_W = MODE_W + SEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] acc_in,
    input logic              carry_in,
    input logic [CTRL_W-1:0] ctrl,
    input logic [DATA_W-1:0] acc_out,
    input logic              carry_out,
    input logic              done,
    input logic              illegal,
    input logic              busy
);
    logic take, legal_mode;
    assign take       = start && !busy;
    assign legal_mode = ctrl[CTRL_W-1:SEL_W] <= MODE_W'(8);

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);

    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && legal_mode && $countones(ctrl[SEL_W-1:0]) == 1) |=> !done ##1 done);

    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && legal_mode && ctrl[SEL_W-1:0] == '0) |=>
            done && !illegal && acc_out == $past(acc_in) && carry_out == $past(carry_in));

    p_bad_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !legal_mode) |=>
            done && illegal && acc_out == $past(acc_in) && carry_out == $past(carry_in));

    p_illegal_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    p_stay_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(acc_out) && $stable(carry_out));
endmodule

bind shrot_unit shrot_unit_chk #(
    .DATA_W(DATA_W), .MODE_W(MODE_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
    .carry_in(carry_in), .ctrl(ctrl), .acc_out(acc_out),
    .carry_out(carry_out), .done(done), .illegal(illegal), .busy(busy)
);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] acc_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] ctrl = '0;
    logic [7:0] acc_out;
    logic       carry_out, done, illegal, busy;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] a;
        logic       v;
        logic       ill;
        int         at;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shrot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
        .carry_in(carry_in), .ctrl(ctrl), .acc_out(acc_out),
        .carry_out(carry_out), .done(done), .illegal(illegal), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(input logic [7:0] a, input logic v, input logic [7:0] c,
                         output logic [7:0] ya, output logic yv, output logic yi,
                         output int lat);
        int n;
        logic nv;
        n  = $countones(c[3:0]);
        ya = a;
        yv = v;
        yi = (c[7:4] > 4'h8);
        if (yi || n == 0) begin
            lat = 1;
        end else begin
            lat = n + 1;
            for (int k = 0; k < n; k++) begin
                case (c[7:4])
                    4'h0:       begin nv = ya[0]; ya = {1'b0, ya[7:1]};  end
                    4'h1, 4'h3: begin nv = ya[0]; ya = {yv, ya[7:1]};    end
                    4'h2:       begin nv = ya[0]; ya = {ya[0], ya[7:1]}; end
                    4'h8:       begin nv = ya[0]; ya = {ya[7], ya[7:1]}; end
                    4'h4:       begin nv = ya[7]; ya = {ya[6:0], 1'b0};  end
                    4'h5, 4'h7: begin nv = ya[7]; ya = {ya[6:0], yv};    end
                    default:    begin nv = ya[7]; ya = {ya[6:0], ya[7]}; end
                endcase
                yv = nv;
            end
        end
    endtask

    // Driver: pushes the expected item, then launches the operation
    task automatic run_op(input logic [7:0] a, input logic v, input logic [7:0] c,
                          input string req);
        exp_t e;
        int lat;
        @(negedge clk);
        model(a, v, c, e.a, e.v, e.ill, lat);
        e.at  = cyc + lat;
        e.req = req;
        sb.push_back(e);
        acc_in = a; carry_in = v; ctrl = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (lat > 1) chk(busy === 1'b1, "R2", "busy while stepping", int'(busy), 1);
        wait (sb.size() == 0);
        @(negedge clk);
        @(negedge clk);
        chk(acc_out === e.a && carry_out === e.v && done === 1'b0, "R12",
            "result held after done", int'({done, carry_out, acc_out}), int'({1'b0, e.v, e.a}));
    endtask

    // Monitor: compares each completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.at, e.req, "done cycle", cyc, e.at);
                chk(acc_out === e.a, e.req, "acc_out", int'(acc_out), int'(e.a));
                chk(carry_out === e.v, e.req, "carry_out", int'(carry_out), int'(e.v));
                chk(illegal === e.ill, e.req, "illegal", int'(illegal), int'(e.ill));
            end
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cyc > 100000) begin
            chk(1'b0, "WDOG", "run timed out", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(acc_out === 8'h00 && carry_out === 1'b0, "R1", "reset result",
            int'({carry_out, acc_out}), 0);
        chk(done === 1'b0 && busy === 1'b0 && illegal === 1'b0, "R1", "reset flags",
            int'({done, busy, illegal}), 0);
        rst_n = 1'b1;

        run_op(8'hB5, 1'b0, 8'h03, "R3");  // logical right, 2 steps
        run_op(8'h96, 1'b1, 8'h8F, "R3");  // arithmetic right, 4 steps, negative
        run_op(8'h6D, 1'b0, 8'h85, "R3");  // arithmetic right, positive
        run_op(8'h35, 1'b0, 8'h2B, "R4");  // rotate right, 3 steps
        run_op(8'h81, 1'b1, 8'h1A, "R5");  // right through carry, 2 steps
        run_op(8'h81, 1'b1, 8'h3A, "R5");  // same via alternate code
        run_op(8'hC3, 1'b0, 8'h4C, "R6");  // logical left, 2 steps
        run_op(8'hA1, 1'b0, 8'h6E, "R6");  // rotate left, 3 steps
        run_op(8'h7E, 1'b1, 8'h51, "R7");  // left through carry, 1 step
        run_op(8'h7E, 1'b1, 8'h7F, "R7");  // alternate code, 4 steps
        run_op(8'h01, 1'b0, 8'h08, "R8");  // carry takes bit 0
        run_op(8'h80, 1'b0, 8'h44, "R8");  // carry takes bit 7
        run_op(8'h5A, 1'b1, 8'h00, "R9");  // zero count
        run_op(8'h5A, 1'b0, 8'h70, "R9");
        run_op(8'hE7, 1'b1, 8'h9F, "R10"); // illegal modes
        run_op(8'h3C, 1'b0, 8'hF0, "R10");
        run_op(8'h00, 1'b0, 8'hA1, "R10");
        run_op(8'hFF, 1'b0, 8'h2F, "R2");  // full count

        // R11: starts while busy must be ignored
        begin
            exp_t e;
            int lat;
            @(negedge clk);
            model(8'h93, 1'b0, 8'h6F, e.a, e.v, e.ill, lat);
            e.at  = cyc + lat;
            e.req = "R11";
            sb.push_back(e);
            acc_in = 8'h93; carry_in = 1'b0; ctrl = 8'h6F; start = 1'b1;
            @(negedge clk);
            acc_in = 8'h00; carry_in = 1'b1; ctrl = 8'hF0;
            repeat (3) @(negedge clk);
            start = 1'b0;
            wait (sb.size() == 0);
            repeat (6) @(negedge clk);
            chk(acc_out === e.a && carry_out === e.v, "R11", "result after ignored start",
                int'({carry_out, acc_out}), int'({e.v, e.a}));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule